// File: doc/BRIEF.md
# Tone-pair frequency classifier

This block takes two hard-limited, clock-synchronous square waves. One carries the low band of a telephone keypad signal and the other the high band. It measures each wave's period by counting reference-clock cycles between successive rising edges. Each period is compared against four fixed count windows per band. A window is centred on a keypad tone and sized so that small deviations pass and larger ones fail.

A band is declared locked only after a run of consecutive periods all land in the same window. One stray period, or a silence longer than a timeout, drops the lock. Requiring a run resists speech and other signals that only briefly look like a tone.

While both bands are locked together, the block raises an early-steering flag. It also presents a 2-bit row index, taken from the low band, and a 2-bit column index, taken from the high band. Duration checking of the flag is left to downstream logic.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: After reset, est_o is 0 and row_o and col_o are 0.
- R2: Low-band tones 697, 770, 852 and 941 Hz give row_o codes 0, 1, 2 and 3. High-band tones 1209, 1336, 1477 and 1633 Hz give col_o codes 0, 1, 2 and 3.
- R3: A tone off its nominal frequency by up to 1.5 % plus 2 Hz, in either direction, is still classified to that tone.
- R4: A tone off every nominal frequency by 3.5 % or more is never classified, so est_o stays 0.
- R5: est_o is 1 only while both bands are locked. A tone present in one band alone never raises it.
- R6: A band locks on the RUN_LEN-th consecutive in-window period of one tone, not earlier. With a steady pair, est_o is 0 before that period ends and 1 a few cycles after.
- R7: Periods that alternate between two different tones of a band never lock that band.
- R8: One out-of-window period in a locked band clears its lock, and est_o falls within one cycle of that.
- R9: When no rising edge arrives in a band for TMO_HZ⁻¹ seconds (clock cycles CLK_HZ/TMO_HZ), that band's lock clears and est_o falls.
- R10: row_o and col_o load in the same cycle that est_o rises and hold constant while est_o stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| lo_sq_i | input | 1 | Limited low-band square wave |
| hi_sq_i | input | 1 | Limited high-band square wave |
| est_o | output | 1 | Early steering: both bands locked |
| row_o | output | 2 | Low-band tone index |
| col_o | output | 2 | High-band tone index |

## Verification
The two bands reaching lock in the same cycle is the coincidence that matters. In that cycle the flag rise and the loading of both indices must happen together, with no cycle that shows a partial result. The bench provokes it by delaying the high-band tone by RUN_LEN times the difference of the two periods, so that both run counters complete on the same edge. It then judges the first cycle with est_o high: row and column must already carry the expected pair there, and must stay fixed afterwards.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

    typedef enum logic {
        GRP_LOW  = 1'b0,
        GRP_HIGH = 1'b1
    } grp_e;

    localparam int NUM_BINS = 4;
    localparam int BIN_W    = 2;

    typedef struct packed {
        logic             hit;
        logic [BIN_W-1:0] bin;
    } cls_t;

    // nominal tone frequency of one bin in one band, in Hz
    function automatic int tone_hz(grp_e grp, int idx);
        int f;
        if (grp == GRP_LOW) begin
            case (idx)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end else begin
            case (idx)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // shortest accepted period count (tone at its highest accepted frequency)
    function automatic int cnt_min(longint clk_hz, int f_hz, int tol_pm);
        return int'((clk_hz * 1000) / (longint'(f_hz) * longint'(1000 + tol_pm)));
    endfunction

    // longest accepted period count (tone at its lowest accepted frequency)
    function automatic int cnt_max(longint clk_hz, int f_hz, int tol_pm);
        return int'((clk_hz * 1000) / (longint'(f_hz) * longint'(1000 - tol_pm)));
    endfunction

endpackage

// File: rtl/sq_edge_sync.sv
module sq_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic sq_i,
    output logic rise_o
);
    logic [2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[1:0], sq_i};
    end

    assign rise_o = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/tone_bin_classifier.sv
module tone_bin_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int   CLK_HZ = 3579545,
    parameter int   TOL_PM = 25,
    parameter grp_e GRP    = GRP_LOW,
    parameter int   MW     = 14
) (
    input  logic [MW-1:0] meas_i,
    output cls_t          cls_o
);
    logic [NUM_BINS-1:0] hit_vec;

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        localparam int LO = cnt_min(longint'(CLK_HZ), tone_hz(GRP, b), TOL_PM);
        localparam int HI = cnt_max(longint'(CLK_HZ), tone_hz(GRP, b), TOL_PM);
        assign hit_vec[b] = (int'(meas_i) >= LO) && (int'(meas_i) <= HI);
    end

    always_comb begin
        cls_o.hit = |hit_vec;
        cls_o.bin = '0;
        for (int b = NUM_BINS - 1; b >= 0; b--) begin
            if (hit_vec[b]) cls_o.bin = BIN_W'(b);
        end
    end
endmodule

// File: rtl/tone_group_detector.sv
module tone_group_detector
    import dtmf_cls_pkg::*;
#(
    parameter int   CLK_HZ  = 3579545,
    parameter int   TOL_PM  = 25,
    parameter int   RUN_LEN = 4,
    parameter int   TMO_CYC = 7159,
    parameter grp_e GRP     = GRP_LOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sq_i,
    output logic             valid_o,
    output logic [BIN_W-1:0] idx_o
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam int MW    = CNT_W + 1;
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic             have_ref_q;
    logic [RUN_W-1:0] run_q;
    logic             valid_q;
    logic [BIN_W-1:0] bin_q;
    logic [MW-1:0]    meas;
    cls_t             cls;
    logic             tmo_hit;

    sq_edge_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .sq_i  (sq_i),
        .rise_o(rise)
    );

    assign meas = {1'b0, cnt_q} + MW'(1);

    tone_bin_classifier #(
        .CLK_HZ(CLK_HZ),
        .TOL_PM(TOL_PM),
        .GRP   (GRP),
        .MW    (MW)
    ) u_cls (
        .meas_i(meas),
        .cls_o (cls)
    );

    assign tmo_hit = !rise && (cnt_q == CNT_W'(TMO_CYC - 1));

    // period counter, saturating at the timeout
    always_ff @(posedge clk) begin
        if (rst)                             cnt_q <= CNT_W'(TMO_CYC);
        else if (rise)                       cnt_q <= '0;
        else if (cnt_q != CNT_W'(TMO_CYC))   cnt_q <= cnt_q + CNT_W'(1);
    end

    // run-length tracking of one bin
    always_ff @(posedge clk) begin
        if (rst) begin
            have_ref_q <= 1'b0;
            run_q      <= '0;
            valid_q    <= 1'b0;
            bin_q      <= '0;
        end else if (tmo_hit) begin
            have_ref_q <= 1'b0;
            run_q      <= '0;
            valid_q    <= 1'b0;
        end else if (rise) begin
            have_ref_q <= 1'b1;
            if (have_ref_q) begin
                if (!cls.hit) begin
                    run_q   <= '0;
                    valid_q <= 1'b0;
                end else if (cls.bin == bin_q && run_q != '0) begin
                    if (run_q != RUN_W'(RUN_LEN)) run_q <= run_q + RUN_W'(1);
                    valid_q <= (run_q + RUN_W'(1)) >= RUN_W'(RUN_LEN);
                end else begin
                    bin_q   <= cls.bin;
                    run_q   <= RUN_W'(1);
                    valid_q <= (RUN_LEN == 1);
                end
            end
        end
    end

    assign valid_o = valid_q;
    assign idx_o   = bin_q;

    // R6: lock only appears right after a measured edge
    a_r6_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(rise));

    // R9: silence reaching the timeout removes the lock
    a_r9_timeout_clears: assert property (@(posedge clk) disable iff (rst)
        tmo_hit |=> !valid_q);

    // R10: bin cannot change under a held lock
    a_r10_bin_held: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(valid_q)) |-> $stable(bin_q));
endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
    import dtmf_cls_pkg::*;
#(
    parameter int CLK_HZ  = 3579545,
    parameter int TOL_PM  = 25,
    parameter int RUN_LEN = 4,
    parameter int TMO_HZ  = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lo_sq_i,
    input  logic       hi_sq_i,
    output logic       est_o,
    output logic [1:0] row_o,
    output logic [1:0] col_o
);
    localparam int TMO_CYC = CLK_HZ / TMO_HZ;
    localparam int NGRP    = 2;

    logic [NGRP-1:0]  grp_valid;
    logic [BIN_W-1:0] grp_idx [NGRP];
    logic [NGRP-1:0]  grp_sq;

    logic             est_q;
    logic [BIN_W-1:0] row_q;
    logic [BIN_W-1:0] col_q;
    logic             both;

    assign grp_sq = {hi_sq_i, lo_sq_i};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        tone_group_detector #(
            .CLK_HZ (CLK_HZ),
            .TOL_PM (TOL_PM),
            .RUN_LEN(RUN_LEN),
            .TMO_CYC(TMO_CYC),
            .GRP    ((g == 0) ? GRP_LOW : GRP_HIGH)
        ) u_det (
            .clk    (clk),
            .rst    (rst),
            .sq_i   (grp_sq[g]),
            .valid_o(grp_valid[g]),
            .idx_o  (grp_idx[g])
        );
    end

    assign both = &grp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            est_q <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else begin
            est_q <= both;
            if (both && !est_q) begin
                row_q <= grp_idx[0];
                col_q <= grp_idx[1];
            end
        end
    end

    assign est_o = est_q;
    assign row_o = row_q;
    assign col_o = col_q;

    // R5 / R8: losing either band drops the flag on the next cycle
    a_r8_drop_follows: assert property (@(posedge clk) disable iff (rst)
        !both |=> !est_o);

    // R10: indices frozen while the flag is held
    a_r10_hold_idx: assert property (@(posedge clk) disable iff (rst)
        (est_o && $past(est_o)) |-> ($stable(row_o) && $stable(col_o)));

    // R10: indices loaded together with the rise of the flag
    a_r10_load_idx: assert property (@(posedge clk) disable iff (rst)
        $rose(est_o) |-> (row_o == $past(grp_idx[0]) && col_o == $past(grp_idx[1])));
endmodule

// File: tb/tb_dtmf_pair_classifier.sv
`timescale 1ns/1ps
module tb_dtmf_pair_classifier;
    localparam int  CLK_HZ  = 400000;
    localparam int  RUN_LEN = 4;
    localparam int  TMO_HZ  = 500;
    localparam int  TMO     = CLK_HZ / TMO_HZ;
    localparam real CLKR    = 400000.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lo_sq, hi_sq;
    logic       est;
    logic [1:0] row, col;

    int total = 0;
    int bad   = 0;

    int lo_pa = 0, lo_pb = 0, hi_pa = 0, hi_pb = 0;
    real low_f  [4] = '{697.0, 770.0, 852.0, 941.0};
    real high_f [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

    always #4 clk = ~clk;

    dtmf_pair_classifier #(
        .CLK_HZ (CLK_HZ),
        .TOL_PM (25),
        .RUN_LEN(RUN_LEN),
        .TMO_HZ (TMO_HZ)
    ) dut (
        .clk    (clk),
        .rst    (rst),
        .lo_sq_i(lo_sq),
        .hi_sq_i(hi_sq),
        .est_o  (est),
        .row_o  (row),
        .col_o  (col)
    );

    // square-wave generators, period alternating between pa and pb
    int  lo_ph = 0, hi_ph = 0;
    bit  lo_sel = 0, hi_sel = 0;
    initial begin lo_sq = 1'b0; hi_sq = 1'b0; end

    always @(negedge clk) begin : gen_lo
        int cur;
        if (lo_pa == 0) begin
            lo_sq <= 1'b0; lo_ph <= 0; lo_sel <= 1'b0;
        end else begin
            cur = lo_sel ? lo_pb : lo_pa;
            lo_sq <= (lo_ph < cur / 2);
            if (lo_ph + 1 >= cur) begin lo_ph <= 0; lo_sel <= ~lo_sel; end
            else lo_ph <= lo_ph + 1;
        end
    end

    always @(negedge clk) begin : gen_hi
        int cur;
        if (hi_pa == 0) begin
            hi_sq <= 1'b0; hi_ph <= 0; hi_sel <= 1'b0;
        end else begin
            cur = hi_sel ? hi_pb : hi_pa;
            hi_sq <= (hi_ph < cur / 2);
            if (hi_ph + 1 >= cur) begin hi_ph <= 0; hi_sel <= ~hi_sel; end
            else hi_ph <= hi_ph + 1;
        end
    end

    function automatic int per(real f);
        return $rtoi(CLKR / f + 0.5);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_tones(int la, int lb, int ha, int hb);
        @(posedge clk);
        lo_pa = la; lo_pb = lb; hi_pa = ha; hi_pb = hb;
    endtask

    task automatic silence();
        set_tones(0, 0, 0, 0);
        waitn(2 * TMO + 20);
    endtask

    task automatic t_reset();
        waitn(1);
        chk("R1 est", est, 0);
        chk("R1 row", row, 0);
        chk("R1 col", col, 0);
    endtask

    task automatic t_keymap();
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                int pl, ph;
                pl = per(low_f[r]); ph = per(high_f[c]);
                set_tones(pl, pl, ph, ph);
                waitn((RUN_LEN + 1) * pl + 40);
                chk("R2 est", est, 1);
                chk("R2 row", row, r);
                chk("R2 col", col, c);
                silence();
                chk("R9 est after silence", est, 0);
            end
        end
    endtask

    task automatic t_lock_timing();
        int pl, ph;
        pl = per(low_f[1]); ph = per(high_f[2]);
        set_tones(pl, pl, 0, 0);
        waitn(4000);
        chk("R5 single band", est, 0);
        silence();
        set_tones(pl, pl, ph, ph);
        waitn(RUN_LEN * pl - pl / 2);
        chk("R6 before run", est, 0);
        waitn(pl / 2 + 20);
        chk("R6 after run", est, 1);
        chk("R6 row", row, 1);
        chk("R6 col", col, 2);
        silence();
    endtask

    task automatic t_accept();
        int pl, ph;
        pl = per(low_f[0] * 1.015 + 2.0); ph = per(high_f[3] * 1.015 + 2.0);
        set_tones(pl, pl, ph, ph);
        waitn((RUN_LEN + 1) * pl + 40);
        chk("R3 plus est", est, 1);
        chk("R3 plus row", row, 0);
        chk("R3 plus col", col, 3);
        silence();
        pl = per(low_f[3] * 0.985 - 2.0); ph = per(high_f[0] * 0.985 - 2.0);
        set_tones(pl, pl, ph, ph);
        waitn((RUN_LEN + 1) * pl + 40);
        chk("R3 minus est", est, 1);
        chk("R3 minus row", row, 3);
        chk("R3 minus col", col, 0);
        silence();
    endtask

    task automatic t_reject();
        int pl, ph;
        pl = per(low_f[0] * 1.035); ph = per(high_f[1]);
        set_tones(pl, pl, ph, ph);
        waitn(4000);
        chk("R4 low high-side", est, 0);
        silence();
        pl = per(low_f[2]); ph = per(high_f[3] * 0.965);
        set_tones(pl, pl, ph, ph);
        waitn(4000);
        chk("R4 high low-side", est, 0);
        silence();
    endtask

    task automatic t_voice();
        int ph;
        ph = per(high_f[0]);
        set_tones(per(low_f[0]), per(low_f[1]), ph, ph);
        waitn(5000);
        chk("R7 alternating", est, 0);
        silence();
    endtask

    task automatic t_bad_period();
        int pl, ph, pbad;
        pl = per(low_f[2]); ph = per(high_f[1]);
        pbad = per(low_f[2] * 0.94);
        set_tones(pl, pl, ph, ph);
        waitn((RUN_LEN + 1) * pl + 40);
        chk("R8 locked", est, 1);
        set_tones(pbad, pbad, ph, ph);
        waitn(2 * pbad + 20);
        chk("R8 dropped", est, 0);
        silence();
    endtask

    task automatic t_timeout();
        int pl, ph;
        pl = per(low_f[3]); ph = per(high_f[2]);
        set_tones(pl, pl, ph, ph);
        waitn((RUN_LEN + 1) * pl + 40);
        chk("R9 locked", est, 1);
        set_tones(pl, pl, 0, 0);
        waitn(400);
        chk("R9 before timeout", est, 1);
        waitn(TMO - 400 + 20);
        chk("R9 after timeout", est, 0);
        silence();
    endtask

    task automatic t_coincide();
        int pl, ph, d, guard;
        pl = per(low_f[3]); ph = per(high_f[0]);
        d = RUN_LEN * (pl - ph);
        set_tones(pl, pl, 0, 0);
        repeat (d - 1) @(posedge clk);
        set_tones(pl, pl, ph, ph);
        guard = 0;
        @(negedge clk);
        while (est !== 1'b1 && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        chk("R10 rose", est, 1);
        chk("R10 row at rise", row, 3);
        chk("R10 col at rise", col, 0);
        for (int k = 0; k < 8; k++) begin
            waitn(pl / 2);
            chk("R10 hold row", row, 3);
            chk("R10 hold col", col, 0);
        end
        silence();
    endtask

    initial begin
        #(8 * 180000);
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_keymap();
        t_lock_timing();
        t_accept();
        t_reject();
        t_voice();
        t_bad_period();
        t_timeout();
        t_coincide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule